// File: doc/BRIEF.md
# Preempted-Task Switch Table

This unit lets the CPUs of one cluster pick up loop iterations that were interrupted on another CPU. It holds one entry per CPU and one availability bit per entry. When an external interrupt preempts a CPU, the hardware records two values in that CPU's entry: the loop index the CPU was running, used as the task identifier, and the address of its saved context. It then sets the entry's availability bit. No software takes part in this capture.

Before fetching a new iteration, a CPU raises a switch request. The unit searches every available entry at once for the smallest identifier, so the oldest unfinished iteration is always resumed first. It answers with a one-cycle response that carries the chosen context address, and it removes that entry from the available set. When no entry is available, the response tells the CPU not to switch. The availability bits also leave the unit, because the cluster treats an all-zero set as one of the conditions for raising a deadlock interrupt.

Top module: `preempt_switch_unit`

## Requirements
- R1: After reset the availability mask `maskOut` is all zero and `respPulse` and `grantValid` are low.
- R2: A high bit i of `preemptStrobe` at a clock edge stores CPU i's slice of `loopIndexIn` as entry i's identifier and its slice of `xchgAddrIn` as entry i's address, and `maskOut[i]` reads 1 after that edge.
- R3: A capture into an entry that is already available overwrites it, and a later grant of that entry returns the newest identifier and address.
- R4: A request served while no entry is available and no capture arrives in the same cycle gives a response with `respPulse`=1 and `grantValid`=0. In that response `grantId` and `grantAddr` are 0 and the mask does not change.
- R5: A request served while at least one entry is available gives `grantValid`=1. `grantCpu` holds the requester number, and `grantId` and `grantAddr` hold the values of the available entry with the smallest identifier.
- R6: When several available entries share the smallest identifier, the one with the lowest entry index is granted.
- R7: The granted entry's mask bit reads 0 in the same cycle as the response, so no entry is granted twice from a single capture.
- R8: Requests raised in the same cycle are answered one per cycle in ascending CPU number, starting with the lowest.
- R9: A capture and a request in the same cycle are ordered capture first, so the entry just captured can be granted to that request.
- R10: `maskOut` bit i is 1 exactly while entry i holds a captured task that has not yet been granted. An all-zero value means there is no preempted work.
- R11: A request seen at an edge is answered one cycle later, and each response lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| preemptStrobe | input | NUM_CPU | One bit per CPU; high when that CPU is interrupted |
| loopIndexIn | input | NUM_CPU*ID_W | Each CPU's current loop index, CPU i at bits [i*ID_W +: ID_W] |
| xchgAddrIn | input | NUM_CPU*ADDR_W | Each CPU's context address, CPU i at bits [i*ADDR_W +: ADDR_W] |
| switchReq | input | NUM_CPU | One-cycle switch request per CPU |
| respPulse | output | 1 | One-cycle response strobe |
| grantValid | output | 1 | Response orders a switch (0 = no switch) |
| grantCpu | output | CPU_W | CPU number the response belongs to |
| grantId | output | ID_W | Identifier of the granted entry |
| grantAddr | output | ADDR_W | Context address of the granted entry |
| maskOut | output | NUM_CPU | Availability mask sent to the cluster |

## Verification
The bound assertions check several rules on every cycle. Any request produces a response on the next edge. A grant removes exactly one bit from the mask. A no-switch response only happens when the mask, including same-cycle captures, is empty. Between responses the mask changes only through captures. The assertions cannot see which entry was chosen, so minimum selection, tie-breaking toward the lower index, overwrite on a repeated capture, and the order in which a burst of requests is served come only from the bench scenarios. There, a reference model predicts each response and a monitor compares it.

// File: rtl/preempt_switch_pkg.sv
package preempt_switch_pkg;
  // Strobes from the request control to the table datapath
  typedef struct packed {
    logic serve;   // answer one request at this edge
  } swStrobe_t;
endpackage

// File: rtl/switch_req_ctrl.sv
module switch_req_ctrl
  import preempt_switch_pkg::*;
#(
  parameter int NUM_CPU = 4,
  localparam int CPU_W  = $clog2(NUM_CPU)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CPU-1:0] switchReq,
  output swStrobe_t          strobe,
  output logic [CPU_W-1:0]   serveCpu
);
  logic [NUM_CPU-1:0] pendQ;
  logic [NUM_CPU-1:0] allReq;
  logic [NUM_CPU-1:0] pickVec;

  assign allReq = pendQ | switchReq;

  // lowest-numbered requester wins
  always_comb begin
    serveCpu = '0;
    pickVec  = '0;
    for (int i = NUM_CPU - 1; i >= 0; i--) begin
      if (allReq[i]) begin
        serveCpu = CPU_W'(i);
        pickVec  = NUM_CPU'(1) << i;
      end
    end
  end

  assign strobe.serve = |allReq;

  always_ff @(posedge clk) begin
    if (!rst_n) pendQ <= '0;
    else        pendQ <= allReq & ~pickVec;
  end
endmodule

// File: rtl/switch_table_dp.sv
module switch_table_dp
  import preempt_switch_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int ID_W    = 24,
  parameter int ADDR_W  = 16,
  localparam int CPU_W  = $clog2(NUM_CPU)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CPU-1:0]       preemptStrobe,
  input  logic [NUM_CPU*ID_W-1:0]  loopIndexIn,
  input  logic [NUM_CPU*ADDR_W-1:0] xchgAddrIn,
  input  swStrobe_t                strobe,
  input  logic [CPU_W-1:0]         serveCpu,
  output logic                     respPulse,
  output logic                     grantValid,
  output logic [CPU_W-1:0]         grantCpu,
  output logic [ID_W-1:0]          grantId,
  output logic [ADDR_W-1:0]        grantAddr,
  output logic [NUM_CPU-1:0]       maskOut
);
  logic [ID_W-1:0]    idTbl   [NUM_CPU];
  logic [ADDR_W-1:0]  addrTbl [NUM_CPU];
  logic [ID_W-1:0]    effId   [NUM_CPU];
  logic [ADDR_W-1:0]  effAddr [NUM_CPU];
  logic [NUM_CPU-1:0] maskQ, effMask, takeVec;
  logic               found, grantHit;
  logic [CPU_W-1:0]   bestIdx;
  logic [ID_W-1:0]    bestId;

  // capture-first view of each entry
  for (genvar g = 0; g < NUM_CPU; g++) begin : gEntry
    assign effId[g]   = preemptStrobe[g] ? loopIndexIn[g*ID_W +: ID_W]     : idTbl[g];
    assign effAddr[g] = preemptStrobe[g] ? xchgAddrIn[g*ADDR_W +: ADDR_W] : addrTbl[g];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        idTbl[g]   <= '0;
        addrTbl[g] <= '0;
      end else if (preemptStrobe[g]) begin
        idTbl[g]   <= loopIndexIn[g*ID_W +: ID_W];
        addrTbl[g] <= xchgAddrIn[g*ADDR_W +: ADDR_W];
      end
    end
  end

  assign effMask = maskQ | preemptStrobe;

  // masked minimum; strict compare keeps the lower index on ties
  always_comb begin
    found   = 1'b0;
    bestIdx = '0;
    bestId  = '0;
    for (int i = 0; i < NUM_CPU; i++) begin
      if (effMask[i] && (!found || effId[i] < bestId)) begin
        found   = 1'b1;
        bestIdx = CPU_W'(i);
        bestId  = effId[i];
      end
    end
  end

  assign grantHit = strobe.serve & found;
  assign takeVec  = grantHit ? (NUM_CPU'(1) << bestIdx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      maskQ      <= '0;
      respPulse  <= 1'b0;
      grantValid <= 1'b0;
      grantCpu   <= '0;
      grantId    <= '0;
      grantAddr  <= '0;
    end else begin
      maskQ      <= effMask & ~takeVec;
      respPulse  <= strobe.serve;
      grantValid <= grantHit;
      grantCpu   <= serveCpu;
      grantId    <= grantHit ? bestId : '0;
      grantAddr  <= grantHit ? effAddr[bestIdx] : '0;
    end
  end

  assign maskOut = maskQ;
endmodule

// File: rtl/preempt_switch_unit.sv
module preempt_switch_unit
  import preempt_switch_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int ID_W    = 24,
  parameter int ADDR_W  = 16,
  localparam int CPU_W  = $clog2(NUM_CPU)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CPU-1:0]        preemptStrobe,
  input  logic [NUM_CPU*ID_W-1:0]   loopIndexIn,
  input  logic [NUM_CPU*ADDR_W-1:0] xchgAddrIn,
  input  logic [NUM_CPU-1:0]        switchReq,
  output logic                      respPulse,
  output logic                      grantValid,
  output logic [CPU_W-1:0]          grantCpu,
  output logic [ID_W-1:0]           grantId,
  output logic [ADDR_W-1:0]         grantAddr,
  output logic [NUM_CPU-1:0]        maskOut
);
  swStrobe_t        strobe;
  logic [CPU_W-1:0] serveCpu;

  switch_req_ctrl #(.NUM_CPU(NUM_CPU)) uCtrl (
    .clk(clk), .rst_n(rst_n), .switchReq(switchReq),
    .strobe(strobe), .serveCpu(serveCpu)
  );

  switch_table_dp #(.NUM_CPU(NUM_CPU), .ID_W(ID_W), .ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rst_n(rst_n), .preemptStrobe(preemptStrobe),
    .loopIndexIn(loopIndexIn), .xchgAddrIn(xchgAddrIn),
    .strobe(strobe), .serveCpu(serveCpu),
    .respPulse(respPulse), .grantValid(grantValid), .grantCpu(grantCpu),
    .grantId(grantId), .grantAddr(grantAddr), .maskOut(maskOut)
  );
endmodule

// File: rtl/preempt_switch_unit_chk.sv
module preempt_switch_unit_chk #(
  parameter int NUM_CPU = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_CPU-1:0] preemptStrobe,
  input logic [NUM_CPU-1:0] switchReq,
  input logic               respPulse,
  input logic               grantValid,
  input logic [NUM_CPU-1:0] maskOut
);
  assert_req_answered_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (switchReq != '0) |=> respPulse);

  assert_grant_is_resp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    grantValid |-> respPulse);

  assert_noswitch_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (respPulse && !grantValid) |-> ($past(maskOut | preemptStrobe) == '0));

  assert_take_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    grantValid |-> ($countones(maskOut) == $countones($past(maskOut | preemptStrobe)) - 1));

  assert_mask_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !grantValid |-> (maskOut == $past(maskOut | preemptStrobe)));
endmodule

bind preempt_switch_unit preempt_switch_unit_chk #(.NUM_CPU(NUM_CPU)) uChk (
  .clk(clk), .rst_n(rst_n), .preemptStrobe(preemptStrobe), .switchReq(switchReq),
  .respPulse(respPulse), .grantValid(grantValid), .maskOut(maskOut)
);

// File: tb/tb_preempt_switch_unit.sv
module tb_preempt_switch_unit;
  localparam int N = 4, IW = 24, AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    preemptStrobe = '0;
  logic [N*IW-1:0] loopIndexIn = '0;
  logic [N*AW-1:0] xchgAddrIn = '0;
  logic [N-1:0]    switchReq = '0;
  logic            respPulse, grantValid;
  logic [1:0]      grantCpu;
  logic [IW-1:0]   grantId;
  logic [AW-1:0]   grantAddr;
  logic [N-1:0]    maskOut;

  always #2.5 clk = ~clk;  // 200 MHz

  preempt_switch_unit dut (
    .clk(clk), .rst_n(rst_n), .preemptStrobe(preemptStrobe),
    .loopIndexIn(loopIndexIn), .xchgAddrIn(xchgAddrIn), .switchReq(switchReq),
    .respPulse(respPulse), .grantValid(grantValid), .grantCpu(grantCpu),
    .grantId(grantId), .grantAddr(grantAddr), .maskOut(maskOut)
  );

  typedef struct {
    logic          v;
    logic [1:0]    cpu;
    logic [IW-1:0] id;
    logic [AW-1:0] addr;
    string         tag;
  } exp_t;

  exp_t expQ[$];
  int checks = 0, fails = 0;

  // reference model state
  logic [IW-1:0] nId [N];
  logic [AW-1:0] nAddr [N];
  logic [IW-1:0] mId [N];
  logic [AW-1:0] mAddr [N];
  logic [N-1:0]  mMask = '0, mPend = '0;

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes the expected response
  task automatic step(input logic [N-1:0] pre, input logic [N-1:0] req, input string tag);
    exp_t e;
    int c, b;
    @(negedge clk);
    preemptStrobe = pre;
    switchReq = req;
    for (int i = 0; i < N; i++) begin
      loopIndexIn[i*IW +: IW] = nId[i];
      xchgAddrIn[i*AW +: AW] = nAddr[i];
      if (pre[i]) begin
        mId[i] = nId[i]; mAddr[i] = nAddr[i]; mMask[i] = 1'b1;
      end
    end
    mPend |= req;
    if (mPend != '0) begin
      c = -1;
      for (int i = N - 1; i >= 0; i--) if (mPend[i]) c = i;
      mPend[c] = 1'b0;
      b = -1;
      for (int i = 0; i < N; i++)
        if (mMask[i] && (b < 0 || mId[i] < mId[b])) b = i;
      e.cpu = 2'(c);
      e.tag = tag;
      if (b < 0) begin
        e.v = 1'b0; e.id = '0; e.addr = '0;
      end else begin
        e.v = 1'b1; e.id = mId[b]; e.addr = mAddr[b];
        mMask[b] = 1'b0;
      end
      expQ.push_back(e);
    end
    @(posedge clk);
    #1;
    preemptStrobe = '0;
    switchReq = '0;
  endtask

  // monitor: compares each response against the queue
  always @(negedge clk) begin
    if (rst_n && respPulse) begin
      if (expQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL R11: unexpected response cpu=%0d valid=%0b (expected none)", grantCpu, grantValid);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(grantValid == e.v && grantCpu == e.cpu && grantId == e.id && grantAddr == e.addr,
              e.tag, $sformatf("got v=%0b cpu=%0d id=%0d addr=%h, expected v=%0b cpu=%0d id=%0d addr=%h",
                               grantValid, grantCpu, grantId, grantAddr, e.v, e.cpu, e.id, e.addr));
      end
    end
  end

  task automatic checkMask(input logic [N-1:0] expM, input string tag);
    check(maskOut === expM, tag, $sformatf("maskOut=%b expected %b", maskOut, expM));
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      nId[i] = '0; nAddr[i] = '0; mId[i] = '0; mAddr[i] = '0;
    end
    fork
      begin
        repeat (4) @(posedge clk);
        #1 check(maskOut == '0 && !respPulse && !grantValid, "R1",
                 $sformatf("reset mask=%b resp=%0b valid=%0b expected 0/0/0", maskOut, respPulse, grantValid));
        rst_n = 1'b1;

        // R4: request with nothing preempted
        step('0, 4'b0001, "R4");
        step('0, '0, "R11");
        check(!respPulse, "R11", $sformatf("respPulse=%0b expected 0 on idle cycle", respPulse));
        checkMask(4'b0000, "R4");

        // R2: capture on CPU2
        nId[2] = 24'd100; nAddr[2] = 16'h2200;
        step(4'b0100, '0, "R2");
        checkMask(4'b0100, "R2");

        // R5: minimum among several
        nId[0] = 24'd50; nAddr[0] = 16'h2000;
        nId[3] = 24'd70; nAddr[3] = 16'h2300;
        step(4'b1001, '0, "R10");
        checkMask(4'b1101, "R10");
        step('0, 4'b0010, "R5");
        checkMask(4'b1100, "R7");

        // R3: re-capture overwrites
        nId[3] = 24'd30; nAddr[3] = 16'h3300;
        step(4'b1000, '0, "R3");
        step('0, 4'b0001, "R3");
        checkMask(4'b0100, "R3");

        // R6: equal identifiers, lowest index first
        nId[0] = 24'd100; nAddr[0] = 16'h4000;
        nId[1] = 24'd100; nAddr[1] = 16'h4100;
        step(4'b0011, '0, "R6");
        checkMask(4'b0111, "R6");
        step('0, 4'b1000, "R6");
        step('0, 4'b1000, "R6");
        step('0, 4'b1000, "R6");
        checkMask(4'b0000, "R7");

        // R8: burst of requests answered in CPU order
        nId[1] = 24'd9; nAddr[1] = 16'h5100;
        nId[2] = 24'd8; nAddr[2] = 16'h5200;
        step(4'b0110, '0, "R8");
        step('0, 4'b1111, "R8");
        step('0, '0, "R8");
        step('0, '0, "R8");
        step('0, '0, "R8");
        checkMask(4'b0000, "R7");

        // R9: capture and request together
        nId[1] = 24'd77; nAddr[1] = 16'h6100;
        step(4'b0010, 4'b0001, "R9");
        checkMask(4'b0000, "R9");

        step('0, '0, "R11");
        step('0, '0, "R11");
        check(expQ.size() == 0, "R11", $sformatf("%0d responses missing, expected 0", expQ.size()));
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run hung, expected completion");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule